// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds recently used page translations in a small, fully associative store. On each lookup it compares the requested virtual page number and the current address-space identifier against every entry at once. On a hit it returns the physical frame number and the permission bits of that entry. Because each entry carries its own address-space tag, a context switch does not require the store to be emptied. Translations from different processes sit side by side, and only the entry whose tag matches the requester can hit.

After a miss, the page-table walker outside this block hands the fetched translation to the refill port. The refill either updates an entry that already holds the same page and tag, or takes a slot chosen by a round-robin pointer. That pointer never lands on an entry marked wired, so wired translations stay resident until reset.

Two flush commands exist: one drops every unwired entry, and the other drops only the unwired entries of one address space. Each lookup result is registered, including the permission check against the access type.

Top module: `tlb_asid`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, and `lkp_hit_o`, `lkp_miss_o`, `perm_fault_o` and `fill_err_o` are low while no request is made.
- R2: A lookup request in cycle N reports its result in cycle N+1. The result is exactly one of `lkp_hit_o` or `lkp_miss_o`, and on a hit it includes the entry's frame number and permission bits.
- R3: A hit requires both the page number and the address-space identifier to match a valid entry. The same page under another identifier misses.
- R4: A refill written in one cycle is visible to a lookup made in the next cycle, which then hits.
- R5: A refill whose page number and identifier match an existing valid entry overwrites that entry. The next lookup returns the new frame, and no two valid entries ever match one lookup.
- R6: The permission bits are bit 0 read, bit 1 write and bit 2 execute. The access codes are 0 load, 1 store and 2 fetch, and code 3 is always refused. A hit whose access is not permitted raises `perm_fault_o` together with `lkp_hit_o`. An execute-only entry (3'b100) faults on a load but not on a fetch.
- R7: A new translation goes to the first unwired entry at or after the round-robin pointer, wrapping at the end. The pointer then moves to the entry after the chosen one. Wired entries are never replaced.
- R8: `flush_all_i` invalidates every unwired entry. Wired entries keep hitting.
- R9: `flush_asid_i` invalidates only the unwired entries whose identifier equals `flush_asid_val_i`. Other identifiers and wired entries keep hitting.
- R10: A refill that matches no entry while every entry is wired is dropped, and `fill_err_o` is high for one cycle in the cycle after that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_req_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Virtual page number to translate |
| lkp_asid_i | input | ASID_W | Address-space identifier of the requester |
| lkp_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| lkp_hit_o | output | 1 | Registered hit |
| lkp_miss_o | output | 1 | Registered miss |
| lkp_pfn_o | output | PFN_W | Frame number on a hit, zero otherwise |
| lkp_perm_o | output | 3 | Permission bits on a hit |
| perm_fault_o | output | 1 | Hit whose access is not permitted |
| fill_req_i | input | 1 | Refill request |
| fill_vpn_i | input | VPN_W | Refill page number |
| fill_asid_i | input | ASID_W | Refill identifier |
| fill_pfn_i | input | PFN_W | Refill frame number |
| fill_perm_i | input | 3 | Refill permission bits |
| fill_wired_i | input | 1 | Mark the refilled entry as wired |
| fill_err_o | output | 1 | Refill dropped because every entry is wired |
| flush_all_i | input | 1 | Invalidate all unwired entries |
| flush_asid_i | input | 1 | Invalidate unwired entries of one identifier |
| flush_asid_val_i | input | ASID_W | Identifier for `flush_asid_i` |

## Verification
The assertions assume that at most one of refill, flush-all or flush-by-identifier is raised in any cycle. The precedence between them is therefore left open. Each scenario task in the bench issues its commands one at a time, separated by at least a cycle, so this assumption holds across the run. Lookups may overlap nothing else either, so every result seen reflects the contents after the previous command has completed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_X = 2;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  function automatic logic perm_ok(input logic [PERM_W-1:0] perm, input logic [1:0] acc);
    case (acc)
      ACC_LOAD:  perm_ok = perm[PERM_R];
      ACC_STORE: perm_ok = perm[PERM_WR];
      ACC_FETCH: perm_ok = perm[PERM_X];
      default:   perm_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tlb_cam.sv
// Parallel tag compare: one match bit per entry.
module tlb_cam #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]         key_vpn_i,
  input  logic [ASID_W-1:0]        key_asid_i,
  output logic [N-1:0]             match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end
endmodule

// File: rtl/tlb_victim.sv
// Round-robin slot picker that skips wired entries.
module tlb_victim #(
  parameter int N = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         wired_i,
  input  logic                 take_i,
  output logic [$clog2(N)-1:0] victim_o,
  output logic                 none_o
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;
  int            idx;

  always_comb begin
    victim_o = '0;
    none_o   = 1'b1;
    idx      = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (none_o && !wired_i[idx]) begin
        victim_o = idx[IW-1:0];
        none_o   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (take_i && !none_o) begin
      ptr_q <= (victim_o == IW'(N-1)) ? '0 : victim_o + IW'(1);
    end
  end

  assert_victim_unwired_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !none_o |-> !wired_i[victim_o]);
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid import tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_req_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [ASID_W-1:0] lkp_asid_i,
  input  logic [1:0]        lkp_acc_i,
  output logic              lkp_hit_o,
  output logic              lkp_miss_o,
  output logic [PFN_W-1:0]  lkp_pfn_o,
  output logic [2:0]        lkp_perm_o,
  output logic              perm_fault_o,
  input  logic              fill_req_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [2:0]        fill_perm_i,
  input  logic              fill_wired_i,
  output logic              fill_err_o,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_val_i
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]              valid_q, wired_q;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0]  perm_q;

  logic [ENTRIES-1:0] l_match, f_match;
  logic [PFN_W-1:0]   rd_pfn;
  logic [PERM_W-1:0]  rd_perm;
  logic               l_any, f_any;
  logic [IW-1:0]      f_idx, victim, wr_idx;
  logic               none_free, wr_en, drop;

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lkp_cam (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lkp_vpn_i), .key_asid_i(lkp_asid_i), .match_o(l_match)
  );

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cam (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i), .match_o(f_match)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .wired_i(wired_q),
    .take_i(fill_req_i && !f_any), .victim_o(victim), .none_o(none_free)
  );

  // OR-reduce the matching entry; at most one can match.
  always_comb begin
    rd_pfn  = '0;
    rd_perm = '0;
    f_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (l_match[i]) begin
        rd_pfn  = rd_pfn | pfn_q[i];
        rd_perm = rd_perm | perm_q[i];
      end
      if (f_match[i]) f_idx = f_idx | IW'(i);
    end
  end

  assign l_any  = |l_match;
  assign f_any  = |f_match;
  assign wr_idx = f_any ? f_idx : victim;
  assign wr_en  = fill_req_i && (f_any || !none_free);
  assign drop   = fill_req_i && !f_any && none_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wired_q <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!wired_q[i] && (flush_all_i || (flush_asid_i && asid_q[i] == flush_asid_val_i)))
          valid_q[i] <= 1'b0;
      end
      if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        wired_q[wr_idx] <= fill_wired_i;
        vpn_q[wr_idx]   <= fill_vpn_i;
        asid_q[wr_idx]  <= fill_asid_i;
        pfn_q[wr_idx]   <= fill_pfn_i;
        perm_q[wr_idx]  <= fill_perm_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_hit_o    <= 1'b0;
      lkp_miss_o   <= 1'b0;
      lkp_pfn_o    <= '0;
      lkp_perm_o   <= '0;
      perm_fault_o <= 1'b0;
      fill_err_o   <= 1'b0;
    end else begin
      lkp_hit_o    <= lkp_req_i && l_any;
      lkp_miss_o   <= lkp_req_i && !l_any;
      lkp_pfn_o    <= (lkp_req_i && l_any) ? rd_pfn : '0;
      lkp_perm_o   <= (lkp_req_i && l_any) ? rd_perm : '0;
      perm_fault_o <= lkp_req_i && l_any && !perm_ok(rd_perm, lkp_acc_i);
      fill_err_o   <= drop;
    end
  end

  // Input assumption: one maintenance command per cycle.
  assert_one_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fill_req_i, flush_all_i, flush_asid_i}));

  assert_req_answered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_req_i |=> (lkp_hit_o ^ lkp_miss_o));

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_req_i |=> !(lkp_hit_o || lkp_miss_o || perm_fault_o));

  assert_no_dup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(l_match));

  assert_fault_on_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_fault_o |-> lkp_hit_o);

  assert_flush_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> ((valid_q & ~wired_q) == '0));

  assert_err_after_fill_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_err_o |-> $past(fill_req_i));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_wchk
    assert_wired_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q[g] && wired_q[g] && !(fill_req_i && f_match[g]))
      |=> (valid_q[g] && wired_q[g] && $stable(vpn_q[g]) && $stable(asid_q[g])));
  end
endmodule

// File: tb/tlb_asid_tb_top.sv
`timescale 1ns/1ps
module tlb_asid_tb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_req = 1'b0;
  logic [19:0] lkp_vpn = '0;
  logic [7:0]  lkp_asid = '0;
  logic [1:0]  lkp_acc = '0;
  logic        hit, miss, fault, ferr;
  logic [19:0] pfn;
  logic [2:0]  perm;
  logic        fill_req = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_wired = 1'b0;
  logic        fl_all = 1'b0;
  logic        fl_asid = 1'b0;
  logic [7:0]  fl_val = '0;

  int checks = 0;
  int errors = 0;
  int wired_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_asid dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_req_i(lkp_req), .lkp_vpn_i(lkp_vpn), .lkp_asid_i(lkp_asid), .lkp_acc_i(lkp_acc),
    .lkp_hit_o(hit), .lkp_miss_o(miss), .lkp_pfn_o(pfn), .lkp_perm_o(perm),
    .perm_fault_o(fault),
    .fill_req_i(fill_req), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_perm_i(fill_perm), .fill_wired_i(fill_wired),
    .fill_err_o(ferr),
    .flush_all_i(fl_all), .flush_asid_i(fl_asid), .flush_asid_val_i(fl_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                      input logic [2:0] pm, input bit w, output logic err);
    @(negedge clk);
    fill_req = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = pm; fill_wired = w;
    @(negedge clk);
    fill_req = 1'b0; fill_wired = 1'b0;
    err = ferr;
  endtask

  task automatic look(input logic [19:0] v, input logic [7:0] a, input logic [1:0] acc,
                      output logic h, output logic m, output logic [19:0] p,
                      output logic [2:0] pm, output logic f);
    @(negedge clk);
    lkp_req = 1'b1; lkp_vpn = v; lkp_asid = a; lkp_acc = acc;
    @(negedge clk);
    lkp_req = 1'b0;
    h = hit; m = miss; p = pfn; pm = perm; f = fault;
  endtask

  // Expect a hit with a given frame.
  task automatic exp_hit(input logic [19:0] v, input logic [7:0] a, input logic [19:0] ep, input string tag);
    logic h, m, f; logic [19:0] p; logic [2:0] pm;
    look(v, a, 2'd0, h, m, p, pm, f);
    chk(h && !m && p == ep, tag, {h, m, 10'd0, p}, {2'b10, 10'd0, ep});
  endtask

  task automatic exp_miss(input logic [19:0] v, input logic [7:0] a, input string tag);
    logic h, m, f; logic [19:0] p; logic [2:0] pm;
    look(v, a, 2'd0, h, m, p, pm, f);
    chk(!h && m && !f, tag, {30'd0, h, m}, 32'd1);
  endtask

  task automatic flush(input bit all, input logic [7:0] a);
    @(negedge clk);
    if (all) fl_all = 1'b1; else begin fl_asid = 1'b1; fl_val = a; end
    @(negedge clk);
    fl_all = 1'b0; fl_asid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!hit && !miss && !fault && !ferr, "R1 idle outputs", {28'd0, hit, miss, fault, ferr}, 32'd0);
    exp_miss(20'h100, 8'd1, "R1 empty after reset");
  endtask

  task automatic t_basic;
    logic e, h, m, f; logic [19:0] p; logic [2:0] pm;
    exp_miss(20'h100, 8'd1, "R4 miss before refill");
    fill(20'h100, 8'd1, 20'h000A5, 3'b011, 1'b0, e);
    chk(!e, "R10 no error on free slot", {31'd0, e}, 32'd0);
    look(20'h100, 8'd1, 2'd1, h, m, p, pm, f);
    chk(h && !m && p == 20'hA5 && pm == 3'b011 && !f, "R2 R4 hit data",
        {8'd0, h, m, f, pm, p[18:0]}, {8'd0, 3'b100, 3'b011, 19'hA5});
  endtask

  task automatic t_asid;
    logic e;
    exp_miss(20'h100, 8'd2, "R3 other asid misses");
    fill(20'h100, 8'd2, 20'h000B7, 3'b011, 1'b0, e);
    exp_hit(20'h100, 8'd2, 20'hB7, "R3 asid 2 frame");
    exp_hit(20'h100, 8'd1, 20'hA5, "R3 asid 1 frame");
  endtask

  task automatic t_overwrite;
    logic e;
    fill(20'h100, 8'd1, 20'h000C3, 3'b011, 1'b0, e);
    exp_hit(20'h100, 8'd1, 20'hC3, "R5 overwrite frame");
  endtask

  task automatic t_perm;
    logic e, h, m, f; logic [19:0] p; logic [2:0] pm;
    fill(20'h200, 8'd1, 20'h00011, 3'b100, 1'b0, e);
    look(20'h200, 8'd1, 2'd0, h, m, p, pm, f);
    chk(h && f, "R6 load on exec-only faults", {30'd0, h, f}, 32'd3);
    look(20'h200, 8'd1, 2'd2, h, m, p, pm, f);
    chk(h && !f, "R6 fetch on exec-only ok", {30'd0, h, f}, 32'd2);
    fill(20'h201, 8'd1, 20'h00012, 3'b001, 1'b0, e);
    look(20'h201, 8'd1, 2'd1, h, m, p, pm, f);
    chk(h && f, "R6 store on read-only faults", {30'd0, h, f}, 32'd3);
    look(20'h201, 8'd1, 2'd0, h, m, p, pm, f);
    chk(h && !f, "R6 load on read-only ok", {30'd0, h, f}, 32'd2);
    look(20'h201, 8'd1, 2'd3, h, m, p, pm, f);
    chk(h && f, "R6 access code 3 refused", {30'd0, h, f}, 32'd3);
  endtask

  task automatic t_flush_asid;
    logic e;
    fill(20'h300, 8'd1, 20'h00033, 3'b111, 1'b1, e);
    wired_cnt++;
    flush(1'b0, 8'd1);
    exp_miss(20'h100, 8'd1, "R9 asid 1 entry cleared");
    exp_miss(20'h200, 8'd1, "R9 asid 1 second entry cleared");
    exp_hit(20'h100, 8'd2, 20'hB7, "R9 asid 2 kept");
    exp_hit(20'h300, 8'd1, 20'h33, "R9 wired kept");
  endtask

  task automatic t_flush_all;
    flush(1'b1, 8'd0);
    exp_miss(20'h100, 8'd2, "R8 unwired cleared");
    exp_hit(20'h300, 8'd1, 20'h33, "R8 wired kept");
  endtask

  task automatic t_round_robin;
    logic e;
    for (int k = 0; k < N - 1; k++)
      fill(20'h1000 + 20'(k), 8'd3, 20'h10000 + 20'(k), 3'b011, 1'b0, e);
    fill(20'h2000, 8'd3, 20'h2AAAA, 3'b011, 1'b0, e);
    exp_miss(20'h1000, 8'd3, "R7 oldest unwired replaced");
    exp_hit(20'h1001, 8'd3, 20'h10001, "R7 next entry kept");
    exp_hit(20'h2000, 8'd3, 20'h2AAAA, "R7 new entry present");
    exp_hit(20'h300, 8'd1, 20'h33, "R7 wired never replaced");
  endtask

  task automatic t_all_wired;
    logic e;
    bit any_err = 1'b0;
    int need = N - wired_cnt;
    for (int k = 0; k < need; k++) begin
      fill(20'h4000 + 20'(k), 8'd5, 20'h40000 + 20'(k), 3'b001, 1'b1, e);
      any_err |= e;
    end
    wired_cnt = N;
    chk(!any_err, "R10 no error while slots remain", {31'd0, any_err}, 32'd0);
    fill(20'h5000, 8'd5, 20'h55555, 3'b001, 1'b0, e);
    chk(e, "R10 error when all wired", {31'd0, e}, 32'd1);
    @(negedge clk);
    chk(!ferr, "R10 error lasts one cycle", {31'd0, ferr}, 32'd0);
    exp_miss(20'h5000, 8'd5, "R10 dropped refill absent");
    exp_hit(20'h4000, 8'd5, 20'h40000, "R10 wired entries intact");
    flush(1'b1, 8'd0);
    exp_hit(20'h4001, 8'd5, 20'h40001, "R8 wired survives flush all");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_asid();
    t_overwrite();
    t_perm();
    t_flush_asid();
    t_flush_all();
    t_round_robin();
    t_all_wired();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule